// File: doc/BRIEF.md
# Frequency Modulation Profile Generator

This block sits ahead of a frequency synthesizer and decides, one cycle at a time, how far the output frequency should sit from the input frequency. The result is a signed offset code in units of 0.01% of the input frequency. Each trigger pulse restarts a cycle count. After a programmable delay the block runs a piecewise-linear profile over a programmable number of cycles. The profile is then held at the center offset until the next trigger arrives.

Four profile shapes can be selected. The first is a flat center offset. Two triangle shapes run in opposite directions. The last is a polygon with four breakpoints and two freely set breakpoint levels. Between breakpoints the offset ramps linearly. The ramp uses integer error accumulation, so each breakpoint level is reached exactly.

Top module: `fm_profiler`

## Requirements
- R1: Out of reset, and until the first trigger, `active_o` is 0 and `offset_o` equals `center_code_i - 256`. The center code is 9 bits, and 256 means zero offset.
- R2: A trigger sampled on a clock edge makes `active_o` rise exactly `start_pos_i` cycles after that edge. In that first active cycle `offset_o` equals the center offset C.
- R3: With `mode_i` = 1, `offset_o` stays at C throughout the active window, which lasts `period_i` cycles.
- R4: With `mode_i` = 2, the profile ramps from C to C+P at relative cycle `pole1_i`. It then ramps to C-P at `pole2_i` and returns to C at `period_i`. P is `peak_code_i`.
- R5: With `mode_i` = 3, the profile is the mirror of R4: it passes C-P at `pole1_i` and C+P at `pole2_i`.
- R6: With `mode_i` = 4, the breakpoints `pole1_i`..`pole4_i` carry these levels in order: L1, X, L3, Y. Here L1 = `lvl1_code_i - 256` and L3 = `lvl3_code_i - 256`. If `lvl3_code_i >= center_code_i`, then X = C-P and Y = C+P; otherwise X = C+P and Y = C-P. The profile returns to C at `period_i`.
- R7: Inside a segment from level A at relative cycle t0 to level B at t1, the offset at relative cycle t equals A + sign(B-A)*floor(|B-A|*(t-t0)/(t1-t0)). The offset equals B exactly at t1.
- R8: After `period_i` active cycles, `active_o` falls and `offset_o` holds C until the next trigger.
- R9: A trigger in any phase restarts the profile. This includes the delay, mid-profile, the last active cycle and the start cycle. `active_o` is 0 in the cycle after the trigger, and the delay of R2 is counted again from the new trigger.
- R10: Mode codes 0, 5, 6 and 7 behave as mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Single-cycle restart pulse |
| mode_i | input | 3 | Profile shape code |
| center_code_i | input | 9 | Center offset, 256 = 0% |
| peak_code_i | input | 8 | Peak deviation magnitude P |
| start_pos_i | input | 10 | Cycles from trigger to profile start |
| period_i | input | 16 | Profile length in cycles |
| pole1_i | input | 16 | First breakpoint, cycles from start |
| pole2_i | input | 16 | Second breakpoint |
| pole3_i | input | 16 | Third breakpoint (polygon only) |
| pole4_i | input | 16 | Fourth breakpoint (polygon only) |
| lvl1_code_i | input | 9 | Polygon first-breakpoint level, 256 = 0% |
| lvl3_code_i | input | 9 | Polygon third-breakpoint level, 256 = 0% |
| offset_o | output | 11 | Signed offset setpoint, 0.01% units |
| active_o | output | 1 | High while the profile runs |

## Verification
A restart trigger can land on the same clock edge as one of the profile's own transitions. Two cases matter: the edge where the start delay expires and the ramp would begin, and the edge where the final segment ends and the block would fall back to hold. Directed runs place the trigger exactly on each of those edges. The bench counts cycles independently and predicts the trigger to win. It then checks that `active_o` is low on the next cycle and that the new start delay is counted in full from the colliding edge.

// File: rtl/fmp_pkg.sv
`timescale 1ns/1ps
package fmp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RUN  = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    localparam logic [2:0] MODE_FLAT   = 3'd1;
    localparam logic [2:0] MODE_TRI_UP = 3'd2;
    localparam logic [2:0] MODE_TRI_DN = 3'd3;
    localparam logic [2:0] MODE_POLY   = 3'd4;

endpackage

// File: rtl/fmp_seg_table.sv
`timescale 1ns/1ps
module fmp_seg_table #(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 9,
    parameter int PEAK_W = 8,
    parameter int LVL_W  = 11
) (
    input  logic [2:0]              mode_i,
    input  logic [2:0]              seg_i,
    input  logic [CODE_W-1:0]       center_code_i,
    input  logic [PEAK_W-1:0]       peak_code_i,
    input  logic [CODE_W-1:0]       lvl1_code_i,
    input  logic [CODE_W-1:0]       lvl3_code_i,
    input  logic [CNT_W-1:0]        pole1_i,
    input  logic [CNT_W-1:0]        pole2_i,
    input  logic [CNT_W-1:0]        pole3_i,
    input  logic [CNT_W-1:0]        pole4_i,
    input  logic [CNT_W-1:0]        period_i,
    output logic signed [LVL_W-1:0] center_lvl_o,
    output logic [CNT_W-1:0]        seg_len_o,
    output logic signed [LVL_W-1:0] lvl_from_o,
    output logic signed [LVL_W-1:0] lvl_to_o,
    output logic                    seg_last_o
);
    import fmp_pkg::*;

    localparam int NPTS = 8;
    localparam logic signed [LVL_W-1:0] ZERO_CODE = LVL_W'(1 << (CODE_W - 1));

    logic signed [LVL_W-1:0] c_lvl, p_lvl, l1_lvl, l3_lvl;
    logic [CNT_W-1:0]        tm [0:NPTS-1];
    logic signed [LVL_W-1:0] lv [0:NPTS-1];
    logic [2:0]              n_seg;
    logic [2:0]              seg_nx;

    assign c_lvl  = $signed({{(LVL_W-CODE_W){1'b0}}, center_code_i}) - ZERO_CODE;
    assign l1_lvl = $signed({{(LVL_W-CODE_W){1'b0}}, lvl1_code_i}) - ZERO_CODE;
    assign l3_lvl = $signed({{(LVL_W-CODE_W){1'b0}}, lvl3_code_i}) - ZERO_CODE;
    assign p_lvl  = $signed({{(LVL_W-PEAK_W){1'b0}}, peak_code_i});

    always_comb begin
        for (int i = 0; i < NPTS; i++) begin
            tm[i] = '0;
            lv[i] = c_lvl;
        end
        tm[1] = period_i;
        n_seg = 3'd1;
        case (mode_i)
            MODE_TRI_UP, MODE_TRI_DN: begin
                tm[1] = pole1_i;
                tm[2] = pole2_i;
                tm[3] = period_i;
                lv[1] = (mode_i == MODE_TRI_UP) ? c_lvl + p_lvl : c_lvl - p_lvl;
                lv[2] = (mode_i == MODE_TRI_UP) ? c_lvl - p_lvl : c_lvl + p_lvl;
                n_seg = 3'd3;
            end
            MODE_POLY: begin
                tm[1] = pole1_i;
                tm[2] = pole2_i;
                tm[3] = pole3_i;
                tm[4] = pole4_i;
                tm[5] = period_i;
                lv[1] = l1_lvl;
                lv[3] = l3_lvl;
                if (lvl3_code_i >= center_code_i) begin
                    lv[2] = c_lvl - p_lvl;
                    lv[4] = c_lvl + p_lvl;
                end else begin
                    lv[2] = c_lvl + p_lvl;
                    lv[4] = c_lvl - p_lvl;
                end
                n_seg = 3'd5;
            end
            default: ;
        endcase
    end

    assign seg_nx       = seg_i + 3'd1;
    assign center_lvl_o = c_lvl;
    assign seg_len_o    = tm[seg_nx] - tm[seg_i];
    assign lvl_from_o   = lv[seg_i];
    assign lvl_to_o     = lv[seg_nx];
    assign seg_last_o   = (seg_nx == n_seg);

endmodule

// File: rtl/fmp_stepper.sv
`timescale 1ns/1ps
module fmp_stepper #(
    parameter int CNT_W  = 16,
    parameter int LVL_W  = 11,
    parameter int STAGES = 4
) (
    input  logic [CNT_W:0]          err_i,
    input  logic signed [LVL_W-1:0] level_i,
    input  logic signed [LVL_W-1:0] lvl_from_i,
    input  logic signed [LVL_W-1:0] lvl_to_i,
    input  logic [CNT_W-1:0]        seg_len_i,
    output logic [CNT_W:0]          err_o,
    output logic signed [LVL_W-1:0] level_o
);
    localparam int ERR_W = CNT_W + 1;

    logic signed [LVL_W:0] diff;
    logic [LVL_W:0]        dmag;
    logic                  going_up;
    logic [ERR_W-1:0]      len_ext;
    logic [ERR_W-1:0]      acc [0:STAGES];
    logic [STAGES-1:0]     hit;
    logic [LVL_W-1:0]      n_steps;

    assign diff     = {lvl_to_i[LVL_W-1], lvl_to_i} - {lvl_from_i[LVL_W-1], lvl_from_i};
    assign going_up = ~diff[LVL_W];
    assign dmag     = going_up ? diff : -diff;
    assign len_ext  = {1'b0, seg_len_i};
    assign acc[0]   = err_i + {{(ERR_W-LVL_W-1){1'b0}}, dmag};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        assign hit[g]   = (acc[g] >= len_ext);
        assign acc[g+1] = hit[g] ? acc[g] - len_ext : acc[g];
    end

    always_comb begin
        n_steps = '0;
        for (int i = 0; i < STAGES; i++) begin
            n_steps = n_steps + {{(LVL_W-1){1'b0}}, hit[i]};
        end
    end

    assign err_o   = acc[STAGES];
    assign level_o = going_up ? level_i + $signed(n_steps) : level_i - $signed(n_steps);

endmodule

// File: rtl/fm_profiler.sv
`timescale 1ns/1ps
module fm_profiler #(
    parameter int CNT_W   = 16,
    parameter int START_W = 10,
    parameter int CODE_W  = 9,
    parameter int PEAK_W  = 8,
    parameter int LVL_W   = 11,
    parameter int STAGES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig_i,
    input  logic [2:0]              mode_i,
    input  logic [CODE_W-1:0]       center_code_i,
    input  logic [PEAK_W-1:0]       peak_code_i,
    input  logic [START_W-1:0]      start_pos_i,
    input  logic [CNT_W-1:0]        period_i,
    input  logic [CNT_W-1:0]        pole1_i,
    input  logic [CNT_W-1:0]        pole2_i,
    input  logic [CNT_W-1:0]        pole3_i,
    input  logic [CNT_W-1:0]        pole4_i,
    input  logic [CODE_W-1:0]       lvl1_code_i,
    input  logic [CODE_W-1:0]       lvl3_code_i,
    output logic signed [LVL_W-1:0] offset_o,
    output logic                    active_o
);
    import fmp_pkg::*;

    localparam int ERR_W = CNT_W + 1;

    typedef struct packed {
        phase_e                  phase;
        logic [2:0]              seg;
        logic [CNT_W-1:0]        k;
        logic [ERR_W-1:0]        err;
        logic signed [LVL_W-1:0] level;
    } st_t;

    localparam st_t ST_RST = '{phase: PH_IDLE, seg: '0, k: '0, err: '0, level: '0};

    st_t st_d, st_q;

    logic signed [LVL_W-1:0] center_lvl, lvl_from, lvl_to, stp_level;
    logic [CNT_W-1:0]        seg_len, wait_last;
    logic [ERR_W-1:0]        stp_err;
    logic                    seg_last;

    fmp_seg_table #(
        .CNT_W (CNT_W),
        .CODE_W(CODE_W),
        .PEAK_W(PEAK_W),
        .LVL_W (LVL_W)
    ) u_table (
        .mode_i       (mode_i),
        .seg_i        (st_q.seg),
        .center_code_i(center_code_i),
        .peak_code_i  (peak_code_i),
        .lvl1_code_i  (lvl1_code_i),
        .lvl3_code_i  (lvl3_code_i),
        .pole1_i      (pole1_i),
        .pole2_i      (pole2_i),
        .pole3_i      (pole3_i),
        .pole4_i      (pole4_i),
        .period_i     (period_i),
        .center_lvl_o (center_lvl),
        .seg_len_o    (seg_len),
        .lvl_from_o   (lvl_from),
        .lvl_to_o     (lvl_to),
        .seg_last_o   (seg_last)
    );

    fmp_stepper #(
        .CNT_W (CNT_W),
        .LVL_W (LVL_W),
        .STAGES(STAGES)
    ) u_stepper (
        .err_i     (st_q.err),
        .level_i   (st_q.level),
        .lvl_from_i(lvl_from),
        .lvl_to_i  (lvl_to),
        .seg_len_i (seg_len),
        .err_o     (stp_err),
        .level_o   (stp_level)
    );

    assign wait_last = {{(CNT_W-START_W){1'b0}}, start_pos_i} - CNT_W'(1);

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_WAIT: begin
                if (st_q.k == wait_last) begin
                    st_d.phase = PH_RUN;
                    st_d.k     = '0;
                    st_d.err   = '0;
                    st_d.level = lvl_from;
                end else begin
                    st_d.k = st_q.k + CNT_W'(1);
                end
            end
            PH_RUN: begin
                if (st_q.k + CNT_W'(1) == seg_len) begin
                    if (seg_last) begin
                        st_d.phase = PH_HOLD;
                    end else begin
                        st_d.seg   = st_q.seg + 3'd1;
                        st_d.k     = '0;
                        st_d.err   = '0;
                        st_d.level = lvl_to;
                    end
                end else begin
                    st_d.k     = st_q.k + CNT_W'(1);
                    st_d.err   = stp_err;
                    st_d.level = stp_level;
                end
            end
            default: ;
        endcase
        if (trig_i) begin
            st_d.phase = PH_WAIT;
            st_d.seg   = '0;
            st_d.k     = '0;
            st_d.err   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign active_o = (st_q.phase == PH_RUN);
    assign offset_o = active_o ? st_q.level : center_lvl;

endmodule

// File: rtl/fm_profiler_chk.sv
`timescale 1ns/1ps
module fm_profiler_chk #(
    parameter int CODE_W = 9,
    parameter int PEAK_W = 8,
    parameter int LVL_W  = 11,
    parameter int STAGES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    trig_i,
    input logic [2:0]              mode_i,
    input logic [CODE_W-1:0]       center_code_i,
    input logic [PEAK_W-1:0]       peak_code_i,
    input logic signed [LVL_W-1:0] offset_o,
    input logic                    active_o
);
    localparam int XW = LVL_W + 2;
    localparam logic signed [XW-1:0] MAX_SLEW = XW'(STAGES - 1);

    logic signed [XW-1:0] c_ref, p_ref, off_x, prev_off, delta;
    logic                 is_tri, is_flat;

    assign c_ref   = $signed({{(XW-CODE_W){1'b0}}, center_code_i}) - $signed(XW'(1 << (CODE_W - 1)));
    assign p_ref   = $signed({{(XW-PEAK_W){1'b0}}, peak_code_i});
    assign off_x   = {{2{offset_o[LVL_W-1]}}, offset_o};
    assign delta   = off_x - prev_off;
    assign is_tri  = (mode_i == 3'd2) || (mode_i == 3'd3);
    assign is_flat = (mode_i != 3'd2) && (mode_i != 3'd3) && (mode_i != 3'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_off <= '0;
        else        prev_off <= off_x;
    end

    a_r9_trig_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> !active_o);

    a_r2_run_starts_at_center: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> (off_x == c_ref));

    // covers R1 as well as R8
    a_r8_idle_holds_center: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (off_x == c_ref));

    // covers R10 as well as R3
    a_r3_flat_profile: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && is_flat) |-> (off_x == c_ref));

    // covers R5 as well as R4
    a_r4_triangle_within_peak: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && is_tri) |-> ((off_x <= c_ref + p_ref) && (off_x >= c_ref - p_ref)));

    a_r7_slew_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && $past(active_o) && !$past(trig_i)) |-> ((delta <= MAX_SLEW) && (delta >= -MAX_SLEW)));

endmodule

bind fm_profiler fm_profiler_chk #(
    .CODE_W(CODE_W),
    .PEAK_W(PEAK_W),
    .LVL_W (LVL_W),
    .STAGES(STAGES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .mode_i       (mode_i),
    .center_code_i(center_code_i),
    .peak_code_i  (peak_code_i),
    .offset_o     (offset_o),
    .active_o     (active_o)
);

// File: tb/fm_profiler_test.sv
`timescale 1ns/1ps
module fm_profiler_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               trig_i = 1'b0;
    logic [2:0]         mode_i = 3'd1;
    logic [8:0]         center_code_i = 9'd256;
    logic [7:0]         peak_code_i = 8'd255;
    logic [9:0]         start_pos_i = 10'd256;
    logic [15:0]        period_i = 16'd8192;
    logic [15:0]        pole1_i = 16'd1638;
    logic [15:0]        pole2_i = 16'd3276;
    logic [15:0]        pole3_i = 16'd4914;
    logic [15:0]        pole4_i = 16'd6552;
    logic [8:0]         lvl1_code_i = 9'd128;
    logic [8:0]         lvl3_code_i = 9'd384;
    logic signed [10:0] offset_o;
    logic               active_o;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    armed = 0;
    int    tcnt = 0;
    bit    done = 0;
    string ovr = "";

    always #5 clk = ~clk;

    fm_profiler uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .mode_i(mode_i),
        .center_code_i(center_code_i), .peak_code_i(peak_code_i),
        .start_pos_i(start_pos_i), .period_i(period_i),
        .pole1_i(pole1_i), .pole2_i(pole2_i), .pole3_i(pole3_i), .pole4_i(pole4_i),
        .lvl1_code_i(lvl1_code_i), .lvl3_code_i(lvl3_code_i),
        .offset_o(offset_o), .active_o(active_o)
    );

    function automatic int cval();
        return int'(center_code_i) - 256;
    endfunction

    // expected offset at relative cycle t inside the active window
    function automatic int prof(int t);
        int tm[6];
        int lv[6];
        int n;
        int c = cval();
        int p = int'(peak_code_i);
        for (int i = 0; i < 6; i++) begin tm[i] = 0; lv[i] = c; end
        n = 1;
        tm[1] = int'(period_i);
        if (mode_i == 3'd2 || mode_i == 3'd3) begin
            tm[1] = int'(pole1_i); tm[2] = int'(pole2_i); tm[3] = int'(period_i);
            lv[1] = (mode_i == 3'd2) ? c + p : c - p;
            lv[2] = (mode_i == 3'd2) ? c - p : c + p;
            n = 3;
        end else if (mode_i == 3'd4) begin
            tm[1] = int'(pole1_i); tm[2] = int'(pole2_i);
            tm[3] = int'(pole3_i); tm[4] = int'(pole4_i); tm[5] = int'(period_i);
            lv[1] = int'(lvl1_code_i) - 256;
            lv[3] = int'(lvl3_code_i) - 256;
            lv[2] = (lvl3_code_i >= center_code_i) ? c - p : c + p;
            lv[4] = (lvl3_code_i >= center_code_i) ? c + p : c - p;
            n = 5;
        end
        for (int i = 0; i < n; i++) begin
            if (t < tm[i+1]) begin
                int d = lv[i+1] - lv[i];
                int ad = (d < 0) ? -d : d;
                int m = ad * (t - tm[i]) / (tm[i+1] - tm[i]);
                return (d >= 0) ? lv[i] + m : lv[i] - m;
            end
        end
        return c;
    endfunction

    task automatic check_now();
        int    st = int'(start_pos_i);
        bit    ea = armed && (tcnt >= st) && (tcnt < st + int'(period_i));
        int    eo = ea ? prof(tcnt - st) : cval();
        string tag;
        if (!armed)                tag = "R1";
        else if (tcnt < st)        tag = "R2";
        else if (!ea)              tag = "R8";
        else if (mode_i == 3'd2)   tag = "R4/R7";
        else if (mode_i == 3'd3)   tag = "R5/R7";
        else if (mode_i == 3'd4)   tag = "R6/R7";
        else if (mode_i == 3'd1)   tag = "R3";
        else                       tag = "R10";
        if (ovr != "") tag = ovr;
        n_vec++;
        if (active_o !== ea || int'(offset_o) != eo) begin
            n_bad++;
            $display("FAIL %s tcnt=%0d active=%0d exp %0d offset=%0d exp %0d",
                     tag, tcnt, active_o, ea, int'(offset_o), eo);
        end
    endtask

    task automatic cycle(bit tr);
        trig_i = tr;
        @(posedge clk);
        if (tr) begin armed = 1; tcnt = 0; end
        else if (armed) tcnt++;
        @(negedge clk);
        check_now();
    endtask

    task automatic run_full(int extra);
        cycle(1);
        repeat (int'(start_pos_i) + int'(period_i) + extra) cycle(0);
    endtask

    task automatic pick_random(logic [2:0] m);
        int sp1 = 500 + int'($urandom % 300);
        int sp2 = 500 + int'($urandom % 300);
        int sp3 = 500 + int'($urandom % 300);
        int sp4 = 500 + int'($urandom % 300);
        int sp5 = 500 + int'($urandom % 300);
        mode_i        = m;
        start_pos_i   = 10'(100 + $urandom % 200);
        peak_code_i   = 8'(30 + $urandom % 226);
        center_code_i = 9'(150 + $urandom % 211);
        pole1_i = 16'(sp1);
        pole2_i = 16'(sp1 + sp2);
        pole3_i = 16'(sp1 + sp2 + sp3);
        pole4_i = 16'(sp1 + sp2 + sp3 + sp4);
        if (m == 3'd4)                   period_i = pole4_i + 16'(sp5);
        else if (m == 3'd2 || m == 3'd3) period_i = pole2_i + 16'(sp5);
        else                             period_i = 16'(1500 + $urandom % 1000);
        if ($urandom % 2 == 0) begin
            lvl1_code_i = center_code_i - 9'(10 + $urandom % 100);
            lvl3_code_i = center_code_i + 9'(10 + $urandom % 100);
        end else begin
            lvl1_code_i = center_code_i + 9'(10 + $urandom % 100);
            lvl3_code_i = center_code_i - 9'(10 + $urandom % 100);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL all watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_now();                      // R1 reset state
        repeat (20) cycle(0);             // R1 idle before any trigger

        // R3: flat profile, off-center
        mode_i = 3'd1; center_code_i = 9'd300; start_pos_i = 10'd100; period_i = 16'd1500;
        run_full(10);

        // R4: steep triangle, minimum spacings, full peak (multi-step cycles)
        mode_i = 3'd2; center_code_i = 9'd256; peak_code_i = 8'd255;
        pole1_i = 16'd500; pole2_i = 16'd1000; period_i = 16'd1500; start_pos_i = 10'd100;
        run_full(10);

        // R5: mirrored triangle
        mode_i = 3'd3; center_code_i = 9'd200; peak_code_i = 8'd30;
        pole1_i = 16'd700; pole2_i = 16'd1300; period_i = 16'd1900;
        run_full(10);

        // R6: polygon, third level above center
        mode_i = 3'd4; center_code_i = 9'd256; peak_code_i = 8'd200;
        lvl1_code_i = 9'd128; lvl3_code_i = 9'd384;
        pole1_i = 16'd500; pole2_i = 16'd1000; pole3_i = 16'd1500; pole4_i = 16'd2000;
        period_i = 16'd2500;
        run_full(10);

        // R6: polygon, reversed arrangement
        lvl1_code_i = 9'd330; lvl3_code_i = 9'd170;
        run_full(10);

        // R10: undefined mode codes act as flat
        mode_i = 3'd0; center_code_i = 9'd10;
        run_full(5);
        mode_i = 3'd7; center_code_i = 9'd500;
        run_full(5);

        // R9: restart mid-profile, then during the start delay
        pick_random(3'd2);
        cycle(1);
        repeat (int'(start_pos_i) + 700) cycle(0);
        ovr = "R9";
        cycle(1);
        repeat (50) cycle(0);
        cycle(1);
        ovr = "";
        repeat (int'(start_pos_i) + int'(period_i) + 5) cycle(0);

        // R9: trigger collides with delay expiry
        pick_random(3'd4);
        cycle(1);
        repeat (int'(start_pos_i) - 1) cycle(0);
        ovr = "R9";
        cycle(1);
        ovr = "";
        repeat (int'(start_pos_i) + int'(period_i) - 1) cycle(0);
        // R9: trigger collides with the last active cycle
        ovr = "R9";
        cycle(1);
        ovr = "";
        repeat (int'(start_pos_i) + int'(period_i) + 5) cycle(0);

        // random profiles across all shapes (R3..R8)
        for (int r = 0; r < 8; r++) begin
            pick_random(3'(1 + (r % 4)));
            run_full(int'($urandom % 20));
        end

        finish_run();
    end

endmodule